// File: doc/BRIEF.md
# Indexed Interrupt Redirection Register File

This block holds the routing state of an I/O interrupt router and exposes all of it through just two 32-bit locations on a simple register bus. The location at byte offset 0x00 is an index (select) register. The location at byte offset 0x10 is a data window. A read or write of the window reaches whichever internal register the index currently names.

Behind the window sit three things:
- an identifier register;
- a read-only version register;
- a table of `NUM_LINES` redirection entries.

Each entry is 64 bits wide and is split into a low half and a high half, which occupy two consecutive indices. The low half carries the vector and the mask bit. The high half carries the destination identifier in its top byte.

For every input line the block continuously drives three outputs: the mask state, the vector and the destination, all taken from that line's entry. A downstream delivery stage consumes them. Software typically reads the version register to learn the table size, sets the unit identifier, and initially masks every entry by writing each low half with only the mask bit set and each high half as zero.

Top module: `ioredir_table`

## Requirements
- R1: After reset the index register reads 0, the identifier register holds `ID_RESET` in bits 31:24 and zero elsewhere, every entry's low half is 0x0001_0000 and high half is 0, every `line_mask_o` bit is 1, and `bus_rdata_o` is 0.
- R2: A write to byte offset 0x00 stores `bus_wdata_i[7:0]` as the index. A read of offset 0x00 returns the index in bits 7:0 with zeros above.
- R3: A window write while the index is 0x00 sets the identifier from `bus_wdata_i[31:24]`. A window read at index 0x00 returns the identifier in bits 31:24 and zero in bits 23:0.
- R4: A window read at index 0x01 returns `NUM_LINES-1` in bits 23:16, 0x11 in bits 7:0 and zero elsewhere. Window writes at index 0x01 change nothing.
- R5: The low half of entry n sits at index 0x10+2n and the high half at 0x10+2n+1. Every bit written to a half reads back unchanged.
- R6: `line_mask_o[n]` equals bit 16 of entry n's low half, `line_vec_o[8n+7:8n]` equals bits 7:0 of that low half, and `line_dest_o[8n+7:8n]` equals bits 31:24 of entry n's high half. Each output follows a write in the cycle after it.
- R7: Window reads at any index that is not 0x00, 0x01 or inside the table return 0. Window writes at such an index change no state.
- R8: Bus reads at any byte offset other than 0x00 and 0x10 return 0. Bus writes there change no state.
- R9: `bus_rdata_o` takes the read value in the cycle after a read request (`bus_en_i`=1, `bus_we_i`=0). It holds that value until the next read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_en_i | input | 1 | Access request, one cycle per access |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte offset of the access |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| line_mask_o | output | NUM_LINES | Per-line mask state |
| line_vec_o | output | 8*NUM_LINES | Per-line vector, line n in bits 8n+7:8n |
| line_dest_o | output | 8*NUM_LINES | Per-line destination, line n in bits 8n+7:8n |

## Verification
The bench builds the block with `NUM_LINES`=4 and `ID_RESET`=0x05. With these values the table ends at index 0x17, so index 0x18 (the first unimplemented index past the table) and index 0x0F (the one just below the table) are both exercised next to valid entries. The version field's expected value, 0x03, differs from the default build, which catches a hard-wired table size. A non-zero reset identifier shows that the reset value passes through to bits 31:24.

// File: rtl/ioredir_pkg.sv
package ioredir_pkg;
  localparam logic [7:0]  IDX_ID       = 8'h00;
  localparam logic [7:0]  IDX_VER      = 8'h01;
  localparam logic [7:0]  IDX_TBL_BASE = 8'h10;
  localparam logic [7:0]  OFS_SEL      = 8'h00;
  localparam logic [7:0]  OFS_WIN      = 8'h10;
  localparam logic [7:0]  VERSION_NUM  = 8'h11;
  localparam logic [31:0] LO_RESET     = 32'h0001_0000;
  localparam int          MASK_BIT     = 16;

  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_ID   = 2'd1,
    TGT_VER  = 2'd2,
    TGT_TBL  = 2'd3
  } target_e;
endpackage

// File: rtl/ioredir_select.sv
module ioredir_select (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] sel_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   sel_o <= 8'h00;
    else if (wr_i) sel_o <= wdata_i;
  end

  assert_sel_wr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> sel_o == $past(wdata_i));
  assert_sel_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(sel_o));
endmodule

// File: rtl/ioredir_decode.sv
module ioredir_decode
  import ioredir_pkg::*;
#(
  parameter int NUM_LINES = 24,
  localparam int EW = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic [7:0]    sel_i,
  output target_e       tgt_o,
  output logic [EW-1:0] entry_o,
  output logic          half_o
);
  logic [8:0] off;
  logic       tbl_hit;

  assign off     = {1'b0, sel_i} - {1'b0, IDX_TBL_BASE};
  assign tbl_hit = (sel_i >= IDX_TBL_BASE) && (off < 9'(2 * NUM_LINES));
  assign entry_o = off[EW:1];
  assign half_o  = off[0];

  always_comb begin
    if (sel_i == IDX_ID)       tgt_o = TGT_ID;
    else if (sel_i == IDX_VER) tgt_o = TGT_VER;
    else if (tbl_hit)          tgt_o = TGT_TBL;
    else                       tgt_o = TGT_NONE;
  end
endmodule

// File: rtl/ioredir_entry.sv
module ioredir_entry
  import ioredir_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_lo_i,
  input  logic        wr_hi_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] lo_o,
  output logic [31:0] hi_o,
  output logic        mask_o,
  output logic [7:0]  vec_o,
  output logic [7:0]  dest_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_o <= LO_RESET;
      hi_o <= '0;
    end else begin
      if (wr_lo_i) lo_o <= wdata_i;
      if (wr_hi_i) hi_o <= wdata_i;
    end
  end

  assign mask_o = lo_o[MASK_BIT];
  assign vec_o  = lo_o[7:0];
  assign dest_o = hi_o[31:24];

  assert_lo_wr_mask_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_lo_i |=> (mask_o == $past(wdata_i[MASK_BIT])) && (vec_o == $past(wdata_i[7:0])));
  assert_hi_wr_dest_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_hi_i |=> dest_o == $past(wdata_i[31:24]));
  assert_idle_stable_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_lo_i && !wr_hi_i) |=> ($stable(lo_o) && $stable(hi_o)));
endmodule

// File: rtl/ioredir_table.sv
module ioredir_table
  import ioredir_pkg::*;
#(
  parameter int         NUM_LINES = 24,
  parameter int         ADDR_W    = 8,
  parameter logic [7:0] ID_RESET  = 8'h00,
  localparam int EW = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   bus_en_i,
  input  logic                   bus_we_i,
  input  logic [ADDR_W-1:0]      bus_addr_i,
  input  logic [31:0]            bus_wdata_i,
  output logic [31:0]            bus_rdata_o,
  output logic [NUM_LINES-1:0]   line_mask_o,
  output logic [8*NUM_LINES-1:0] line_vec_o,
  output logic [8*NUM_LINES-1:0] line_dest_o
);
  localparam logic [7:0] LAST_IDX = 8'(NUM_LINES - 1);

  logic          hit_sel, hit_win, sel_wr, win_wr, rd_req;
  logic [7:0]    sel_q, id_q;
  target_e       tgt;
  logic [EW-1:0] entry_idx;
  logic          half;
  logic [31:0]   lo_arr [NUM_LINES];
  logic [31:0]   hi_arr [NUM_LINES];
  logic [31:0]   win_val, rd_val;

  assign hit_sel = bus_addr_i == ADDR_W'(OFS_SEL);
  assign hit_win = bus_addr_i == ADDR_W'(OFS_WIN);
  assign sel_wr  = bus_en_i && bus_we_i && hit_sel;
  assign win_wr  = bus_en_i && bus_we_i && hit_win;
  assign rd_req  = bus_en_i && !bus_we_i;

  ioredir_select u_sel (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (sel_wr),
    .wdata_i (bus_wdata_i[7:0]),
    .sel_o   (sel_q)
  );

  ioredir_decode #(.NUM_LINES(NUM_LINES)) u_dec (
    .sel_i   (sel_q),
    .tgt_o   (tgt),
    .entry_o (entry_idx),
    .half_o  (half)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        id_q <= ID_RESET;
    else if (win_wr && tgt == TGT_ID)   id_q <= bus_wdata_i[31:24];
  end

  for (genvar gi = 0; gi < NUM_LINES; gi++) begin : g_ent
    logic wr_here;
    assign wr_here = win_wr && (tgt == TGT_TBL) && (entry_idx == EW'(gi));
    ioredir_entry u_ent (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_lo_i (wr_here && !half),
      .wr_hi_i (wr_here && half),
      .wdata_i (bus_wdata_i),
      .lo_o    (lo_arr[gi]),
      .hi_o    (hi_arr[gi]),
      .mask_o  (line_mask_o[gi]),
      .vec_o   (line_vec_o[8*gi +: 8]),
      .dest_o  (line_dest_o[8*gi +: 8])
    );
  end

  always_comb begin
    case (tgt)
      TGT_ID:  win_val = {id_q, 24'h0};
      TGT_VER: win_val = {8'h00, LAST_IDX, 8'h00, VERSION_NUM};
      TGT_TBL: win_val = half ? hi_arr[entry_idx] : lo_arr[entry_idx];
      default: win_val = '0;
    endcase
  end

  always_comb begin
    if (hit_sel)      rd_val = {24'h0, sel_q};
    else if (hit_win) rd_val = win_val;
    else              rd_val = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     bus_rdata_o <= '0;
    else if (rd_req) bus_rdata_o <= rd_val;
  end

  assert_rd_unmapped_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req && !hit_sel && !hit_win) |=> bus_rdata_o == 32'h0);
  assert_rd_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_req |=> $stable(bus_rdata_o));
  assert_ver_ro_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_wr && tgt == TGT_VER) |=> ($stable(id_q) && $stable(sel_q)));
  assert_id_only_on_idx0_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(win_wr && tgt == TGT_ID) |=> $stable(id_q));
endmodule

// File: tb/ioredir_table_bench.sv
`timescale 1ns/1ps
module ioredir_table_bench;
  localparam int         N   = 4;
  localparam logic [7:0] IDR = 8'h05;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_en = 1'b0, bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [N-1:0]   mask_o;
  logic [8*N-1:0] vec_o, dest_o;

  always #2.5 clk = ~clk;

  ioredir_table #(.NUM_LINES(N), .ADDR_W(8), .ID_RESET(IDR)) u_ioredir_table (
    .clk_i(clk), .rst_ni(rst_n), .bus_en_i(bus_en), .bus_we_i(bus_we),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .line_mask_o(mask_o), .line_vec_o(vec_o), .line_dest_o(dest_o)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  string cur_tag = "R1";

  // reference model
  logic [31:0] m_lo [N];
  logic [31:0] m_hi [N];
  logic [7:0]  m_sel, m_id;
  logic [31:0] m_rdata;

  function automatic logic [31:0] m_read(input logic [7:0] a);
    int idx;
    if (a == 8'h00) return {24'h0, m_sel};
    if (a != 8'h10) return 32'h0;
    idx = int'(m_sel);
    if (idx == 0) return {m_id, 24'h0};
    if (idx == 1) return {8'h00, 8'(N - 1), 8'h00, 8'h11};
    if (idx >= 16 && idx < 16 + 2 * N)
      return (idx % 2 == 1) ? m_hi[(idx - 16) / 2] : m_lo[(idx - 16) / 2];
    return 32'h0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin m_lo[i] <= 32'h0001_0000; m_hi[i] <= 32'h0; end
      m_sel <= 8'h00; m_id <= IDR; m_rdata <= 32'h0;
    end else if (bus_en) begin
      if (!bus_we) m_rdata <= m_read(bus_addr);
      else if (bus_addr == 8'h00) m_sel <= bus_wdata[7:0];
      else if (bus_addr == 8'h10) begin
        if (m_sel == 8'h00) m_id <= bus_wdata[31:24];
        else if (int'(m_sel) >= 16 && int'(m_sel) < 16 + 2 * N) begin
          if (m_sel[0]) m_hi[(int'(m_sel) - 16) / 2] <= bus_wdata;
          else          m_lo[(int'(m_sel) - 16) / 2] <= bus_wdata;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", tag, act, exp, $time);
    end
  endtask

  // every-clock comparison against the model
  always begin
    @(posedge clk); #1;
    if (rst_n && !done) begin
      chk(bus_rdata === m_rdata, {cur_tag, " rdata (R9)"}, bus_rdata, m_rdata);
      for (int i = 0; i < N; i++) begin
        chk(mask_o[i] === m_lo[i][16], {cur_tag, " mask (R6)"}, 32'(mask_o[i]), 32'(m_lo[i][16]));
        chk(vec_o[8*i +: 8] === m_lo[i][7:0], {cur_tag, " vec (R6)"}, 32'(vec_o[8*i +: 8]), 32'(m_lo[i][7:0]));
        chk(dest_o[8*i +: 8] === m_hi[i][31:24], {cur_tag, " dest (R6)"}, 32'(dest_o[8*i +: 8]), 32'(m_hi[i][31:24]));
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1; bus_en = 0; bus_we = 0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); bus_en = 1; bus_we = 0; bus_addr = a;
    @(posedge clk); #1; bus_en = 0;
    chk(bus_rdata === exp, tag, bus_rdata, exp);
  endtask

  task automatic win_chk(input logic [7:0] idx, input logic [31:0] exp, input string tag);
    wr(8'h00, {24'h0, idx});
    rd_chk(8'h10, exp, tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1; chk(mask_o === '1, "R1 masks at reset", 32'(mask_o), 32'hF);
    chk(bus_rdata === 32'h0, "R1 rdata at reset", bus_rdata, 0);
    @(negedge clk); rst_n = 1;
    cur_tag = "R1";
    rd_chk(8'h00, 32'h0, "R1 index reset");
    rd_chk(8'h10, 32'h0500_0000, "R1 id reset");
    win_chk(8'h14, 32'h0001_0000, "R1 entry2 low reset");
    win_chk(8'h15, 32'h0, "R1 entry2 high reset");

    cur_tag = "R2";
    wr(8'h00, 32'hABCD_EF12);
    rd_chk(8'h00, 32'h12, "R2 index readback");

    cur_tag = "R3";
    wr(8'h00, 32'h0);
    wr(8'h10, 32'hA5FF_FFFF);
    rd_chk(8'h10, 32'hA500_0000, "R3 id write");

    cur_tag = "R4";
    win_chk(8'h01, 32'h0003_0011, "R4 version");
    wr(8'h10, 32'hFFFF_FFFF);
    rd_chk(8'h10, 32'h0003_0011, "R4 version after write");
    win_chk(8'h00, 32'hA500_0000, "R4 id untouched");

    cur_tag = "R5";
    wr(8'h00, 32'h16); wr(8'h10, 32'h0000_0031);
    #1; chk(mask_o[3] === 1'b0, "R6 mask3 cleared", 32'(mask_o[3]), 0);
    chk(vec_o[31:24] === 8'h31, "R6 vec3", 32'(vec_o[31:24]), 32'h31);
    wr(8'h00, 32'h17); wr(8'h10, 32'h7E00_1234);
    #1; chk(dest_o[31:24] === 8'h7E, "R6 dest3", 32'(dest_o[31:24]), 32'h7E);
    win_chk(8'h16, 32'h0000_0031, "R5 entry3 low readback");
    win_chk(8'h17, 32'h7E00_1234, "R5 entry3 high readback");
    wr(8'h00, 32'h10); wr(8'h10, 32'hDEAD_BEFF);
    win_chk(8'h10, 32'hDEAD_BEFF, "R5 entry0 low readback");
    #1; chk(mask_o[0] === 1'b1, "R6 mask0 from bit16", 32'(mask_o[0]), 1);

    cur_tag = "R7";
    wr(8'h00, 32'h18); wr(8'h10, 32'h1234_5678);
    rd_chk(8'h10, 32'h0, "R7 past table reads zero");
    win_chk(8'h0F, 32'h0, "R7 below table reads zero");
    win_chk(8'h02, 32'h0, "R7 index 2 reads zero");
    win_chk(8'hFF, 32'h0, "R7 index FF reads zero");
    win_chk(8'h16, 32'h0000_0031, "R7 entry3 untouched");

    cur_tag = "R8";
    wr(8'h00, 32'h17);
    wr(8'h04, 32'h0000_0055);
    wr(8'h11, 32'h0000_0000);
    rd_chk(8'h00, 32'h17, "R8 index untouched");
    rd_chk(8'h10, 32'h7E00_1234, "R8 entry3 high untouched");
    rd_chk(8'h08, 32'h0, "R8 unmapped offset reads zero");

    cur_tag = "R9";
    rd_chk(8'h10, 32'h7E00_1234, "R9 read");
    repeat (3) @(posedge clk);
    #1; chk(bus_rdata === 32'h7E00_1234, "R9 hold", bus_rdata, 32'h7E00_1234);

    cur_tag = "R6";
    for (int i = 0; i < N; i++) begin
      wr(8'h00, 32'(16 + 2 * i)); wr(8'h10, 32'h0001_0000);
      wr(8'h00, 32'(17 + 2 * i)); wr(8'h10, 32'h0);
    end
    #1; chk(mask_o === '1, "R6 all masked", 32'(mask_o), 32'hF);
    chk(dest_o === '0, "R6 all dest zero", dest_o, 0);

    cur_tag = "R5 sweep";
    for (int k = 0; k < 60; k++) begin
      logic [7:0] ix;
      ix = 8'(k * 7 % 26);
      wr(8'h00, {24'h0, ix});
      wr(8'h10, 32'(k * 32'h0101_3B07));
      rd_chk(8'h10, m_read(8'h10), "R5 sweep readback");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule